// File: doc/BRIEF.md
# Serial Memory Programming Controller

This block is the device-side end of a bit-serial programming port for a small on-chip program memory. A host drives a serial clock, a data line and an active-low program strobe. The controller shifts in a command byte and then four bytes: the address low and high bytes, followed by the data low and high bytes. A low pulse on the strobe writes the word into an internal register array, which stands in for the memory.

With the program-and-verify command, a second strobe pulse copies the addressed word into an output latch. The host then clocks that word back out on the data line, low byte first. The controller takes the data line only from the first falling serial clock edge of the read-out. It releases the line after the sixteenth rising edge. All port inputs are brought into the system clock domain through two-flop synchronizers before any edge is detected.

Top module: `serprog_ctrl`

## Requirements
- R1: After reset the data-line enable `sda_oe` is 0, `sda_o` is 0, and the controller waits for a command byte.
- R2: Every serial field is sampled on rising serial clock edges, least-significant bit first. The order on the line is: command byte, address low byte, address high byte, data low byte, data high byte.
- R3: Command 0x25 is plain program. The first strobe falling edge after the fortieth bit writes the data to the address. Later strobe pulses and serial clocks produce no read-out, so `sda_oe` stays 0.
- R4: Command 0x35 is program-and-verify. After the write pulse and a return to high, a second strobe pulse latches the addressed word. Once the strobe is high again, sixteen serial clocks shift the word out least-significant bit first, low byte then high byte, with bits 9 to 15 sent as 0.
- R5: `sda_oe` stays 0 until the first falling serial clock edge of the read-out, and is 1 from that edge on.
- R6: While the line is driven, `sda_o` changes only after a falling serial clock edge.
- R7: The line is released (`sda_oe` = 0) after the sixteenth read-out rising edge, and the controller accepts a new command frame straight away.
- R8: A command byte other than 0x25 or 0x35 is ignored. The serial clocks and strobe pulses that follow it cause no read-out until the strobe has returned high.
- R9: A strobe falling edge that arrives before all forty frame bits have been received discards the frame. It causes no write and no read-out.
- R10: Only address bits 0 to 10 and data bits 0 to 8 are kept. Any other bits sent in the address high byte or the data high byte are ignored.
- R11: A strobe falling edge during the read-out releases the data line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host (idles high) |
| sda_i | input | 1 | Data line as seen at the pin |
| pgm_n_i | input | 1 | Active-low program strobe |
| sda_o | output | 1 | Data value driven onto the line |
| sda_oe | output | 1 | Output enable for the data line |

## Verification
The bench builds the block with its default parameters: an 11-bit address, a 9-bit word, and command codes 0x25 and 0x35. These values put the top address 0x7FF, the all-ones word 0x1FF, and high bytes with stray upper bits within reach. They show that the field truncation and the zero padding on read-out behave correctly. A scoreboard queue holds each expected read-out word, and a monitor assembles the words from the line. With this, missing, extra and corrupted read-outs are all caught. The bench also covers aborted frames, unknown commands and strobe interruptions.

// File: rtl/serprog_ctrl.sv
module serprog_ctrl #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 9,
  parameter logic [7:0] CMD_PROG = 8'h25,
  parameter logic [7:0] CMD_VRFY = 8'h35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sda_i,
  input  logic pgm_n_i,
  output logic sda_o,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = 16 - DATA_W;

  typedef enum logic [2:0] {
    S_CMD, S_BODY, S_ARMED, S_WHOLD, S_VWAIT, S_VHOLD, S_SHIFT, S_SKIP
  } st_t;

  st_t               st;
  logic [2:0]        sck_q, pgm_q;
  logic [1:0]        sda_q;
  logic [4:0]        cnt;
  logic [7:0]        cmd_sr;
  logic              vmode;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [15:0]       out_sr;
  logic [DATA_W-1:0] mem [DEPTH];

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire pgm_fall = ~pgm_q[1] & pgm_q[2];
  wire pgm_rise = pgm_q[1] & ~pgm_q[2];
  wire din      = sda_q[1];
  wire [7:0] cmd_nx = {din, cmd_sr[7:1]};
  wire wr_en    = (st == S_ARMED) && pgm_fall;
  wire lat_en   = (st == S_VWAIT) && pgm_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 3'b111;
      pgm_q <= 3'b111;
      sda_q <= 2'b00;
    end else begin
      sck_q <= {sck_q[1:0], sclk_i};
      pgm_q <= {pgm_q[1:0], pgm_n_i};
      sda_q <= {sda_q[0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr_q] <= data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CMD;
      cnt    <= '0;
      cmd_sr <= '0;
      vmode  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      out_sr <= '0;
      sda_o  <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        S_CMD: begin
          if (pgm_fall) begin
            st  <= S_SKIP;
            cnt <= '0;
          end else if (sck_rise) begin
            cmd_sr <= cmd_nx;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (cmd_nx == CMD_PROG) begin
                vmode <= 1'b0;
                st    <= S_BODY;
              end else if (cmd_nx == CMD_VRFY) begin
                vmode <= 1'b1;
                st    <= S_BODY;
              end else begin
                st <= S_SKIP;
              end
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
        end
        S_BODY: begin
          if (pgm_fall) begin
            st  <= S_SKIP;
            cnt <= '0;
          end else if (sck_rise) begin
            if (!cnt[4] && (int'(cnt) < ADDR_W)) addr_q[cnt[3:0]] <= din;
            if (cnt[4] && (int'(cnt[3:0]) < DATA_W)) data_q[cnt[3:0]] <= din;
            if (cnt == 5'd31) begin
              cnt <= '0;
              st  <= S_ARMED;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
        end
        S_ARMED: if (pgm_fall) st <= S_WHOLD;
        S_WHOLD: if (pgm_rise) st <= vmode ? S_VWAIT : S_CMD;
        S_VWAIT: begin
          if (pgm_fall) begin
            out_sr <= {{PAD{1'b0}}, mem[addr_q]};
            st     <= S_VHOLD;
          end
        end
        S_VHOLD: begin
          if (pgm_rise) begin
            cnt <= '0;
            st  <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (pgm_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_SKIP;
          end else if (sck_fall) begin
            sda_o  <= out_sr[0];
            out_sr <= {1'b0, out_sr[15:1]};
            sda_oe <= 1'b1;
          end else if (sck_rise && sda_oe) begin
            if (cnt == 5'd15) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_CMD;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
        end
        S_SKIP: begin
          if (pgm_rise) begin
            cnt <= '0;
            st  <= S_CMD;
          end
        end
        default: st <= S_CMD;
      endcase
    end
  end
endmodule

// File: rtl/serprog_ctrl_chk.sv
module serprog_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_rise,
  input logic sck_fall,
  input logic pgm_fall,
  input logic wr_en,
  input logic sda_o,
  input logic sda_oe
);
  p_take_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(sck_fall));

  p_bit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && $past(sda_oe) && !$past(sck_fall)) |-> $stable(sda_o));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(sck_rise) || $past(pgm_fall)));

  p_strobe_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_fall |=> !sda_oe);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !sda_oe);
endmodule

bind serprog_ctrl serprog_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck_rise (sck_rise),
  .sck_fall (sck_fall),
  .pgm_fall (pgm_fall),
  .wr_en    (wr_en),
  .sda_o    (sda_o),
  .sda_oe   (sda_oe)
);

// File: tb/serprog_ctrl_bench.sv
module serprog_ctrl_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1;
  logic sda_i = 1'b0;
  logic pgm_n_i = 1'b1;
  logic sda_o, sda_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] expq[$];
  logic [15:0] got = '0;
  int nb = 0;
  bit oe_seen = 0;

  always #10 clk = ~clk;

  serprog_ctrl u_serprog_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sda_i(sda_i),
    .pgm_n_i(pgm_n_i), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: assemble read-out words at rising sclk, compare against scoreboard
  always @(posedge sclk_i) begin
    if (sda_oe) begin
      oe_seen = 1;
      got[nb] = sda_o;
      nb++;
      if (nb == 16) begin
        nb = 0;
        if (expq.size() == 0) check(1'b0, "R4 unexpected readout", got, 16'hxxxx);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(got == e, "R4 readout word", got, e);
        end
      end
    end else nb = 0;
  end

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_i = 1'b0;
      sda_i  = b[i];
      wait_clk(H);
      sclk_i = 1'b1;
      wait_clk(H);
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    pgm_n_i = 1'b0;
    wait_clk(12);
    pgm_n_i = 1'b1;
    wait_clk(12);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [15:0] a, input logic [15:0] d, input bit sync);
    if (sync) pulse();
    send_byte(cmd);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    send_byte(d[7:0]);
    send_byte(d[15:8]);
  endtask

  task automatic readout(input bit expect_out, input string req);
    oe_seen = 0;
    sda_i = 1'b1;
    if (expect_out) check(sda_oe == 1'b0, "R5 idle before first fall", {15'd0, sda_oe}, 16'd0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sclk_i = 1'b0;
      wait_clk(H);
      if (expect_out && i == 0) check(sda_oe == 1'b1, "R5 driven after first fall", {15'd0, sda_oe}, 16'd1);
      sclk_i = 1'b1;
      wait_clk(H);
    end
    wait_clk(6);
    if (expect_out) check(sda_oe == 1'b0, "R7 released after 16th rise", {15'd0, sda_oe}, 16'd0);
    else check(oe_seen == 1'b0, req, {15'd0, oe_seen}, 16'd0);
  endtask

  task automatic verify(input logic [15:0] a, input logic [15:0] d, input logic [15:0] exp, input bit sync);
    expq.push_back(exp);
    frame(8'h35, a, d, sync);
    pulse();
    pulse();
    readout(1'b1, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 oe after reset", {15'd0, sda_oe}, 16'd0);
    check(sda_o == 1'b0, "R1 sda_o after reset", {15'd0, sda_o}, 16'd0);

    // R2 R4 basic verify, LSB-first framing
    verify(16'h0005, 16'h00A5, 16'h00A5, 1'b0);
    // R7 new frame accepted right after release, no sync pulse
    verify(16'h0123, 16'h0136, 16'h0136, 1'b0);
    // R10 top address and full-width word
    verify(16'h07FF, 16'h01FF, 16'h01FF, 1'b1);
    // R10 stray upper bits in high bytes ignored
    verify(16'hF812, 16'hFE5A, 16'h005A, 1'b1);

    // R3 plain program: no read-out after further pulses
    frame(8'h25, 16'h0040, 16'h0111, 1'b1);
    pulse();
    pulse();
    readout(1'b0, "R3 no readout after plain program");
    verify(16'h0040, 16'h0099, 16'h0099, 1'b1);

    // R8 unknown command ignored
    frame(8'h77, 16'h0010, 16'h0055, 1'b1);
    pulse();
    pulse();
    readout(1'b0, "R8 unknown command");
    verify(16'h0010, 16'h0155, 16'h0155, 1'b1);

    // R9 strobe before frame complete
    pulse();
    send_byte(8'h35);
    send_byte(8'h20);
    send_byte(8'h00);
    send_byte(8'h33);
    pulse();
    pulse();
    readout(1'b0, "R9 early strobe");
    verify(16'h0020, 16'h0066, 16'h0066, 1'b1);

    // R11 strobe during read-out releases line
    frame(8'h35, 16'h0030, 16'h00F0, 1'b1);
    pulse();
    pulse();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sclk_i = 1'b0;
      wait_clk(H);
      sclk_i = 1'b1;
      wait_clk(H);
    end
    @(negedge clk);
    check(sda_oe == 1'b1, "R11 driving mid readout", {15'd0, sda_oe}, 16'd1);
    pgm_n_i = 1'b0;
    wait_clk(6);
    check(sda_oe == 1'b0, "R11 released by strobe", {15'd0, sda_oe}, 16'd0);
    pgm_n_i = 1'b1;
    wait_clk(12);
    verify(16'h0031, 16'h010F, 16'h010F, 1'b1);

    wait_clk(20);
    check(expq.size() == 0, "R4 all expected readouts seen", 16'(expq.size()), 16'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule